// File: doc/BRIEF.md
# Dual Accumulator Shift ALU

This block is the arithmetic and shifting core of a fixed-point datapath. It holds a 32-bit accumulator, a 32-bit buffer that serves as a second accumulator, and a one-bit carry flag. Each cycle with the valid strobe high, it applies one operation and registers the result. An operation can combine the accumulator with the buffer, with a 16-bit operand, or with the carry.

The buffer is the point of the design. The 64-bit shifts and rotates treat buffer and accumulator as one chain, with the buffer as the upper word. The two compare operations copy the accumulator into the buffer when it is larger or smaller, so a running maximum or minimum builds up without extra storage. All three registers drive the outputs directly, and every result appears on the first clock edge after the strobe.

Top module: `dacc_shift_alu`

## Requirements
- R1: After reset, accumulator, buffer and carry are all zero. A cycle with `op_valid` low leaves all three unchanged. Operation codes 28 to 31 are reserved and also leave all three unchanged.
- R2: Code 3 writes accumulator + buffer into the accumulator. Code 1 writes accumulator + buffer + carry into the accumulator. Both set the carry to the unsigned carry-out of bit 31.
- R3: Code 4 writes accumulator − buffer into the accumulator. Code 2 writes accumulator − buffer − (NOT carry) into the accumulator. Both set the carry to 1 when no borrow occurs and to 0 when a borrow occurs.
- R4: The three operand logic operations use zero-extended `operand` bits. Code 5 ANDs the operand with the accumulator, so the upper 16 bits become zero. Code 6 ORs it in and code 7 XORs it in, and both leave the upper 16 bits as they were.
- R5: Code 8 ANDs the buffer into the accumulator. Code 9 ORs it in and code 10 XORs it in. Buffer and carry are unchanged.
- R6: The 1-bit accumulator operations all move bit 31 or bit 0 out into the carry:
  - Code 11 shifts left and fills bit 0 with zero.
  - Code 12 shifts right. Bit 31 keeps its value when `sign_ext` is 1 and becomes zero when `sign_ext` is 0.
  - Code 13 rotates left through the carry.
  - Code 14 rotates right through the carry.
- R7: Codes 15 to 18 act on the 64-bit chain {buffer, accumulator}, with the buffer as the upper word:
  - Code 15 shifts left, fills with zero and moves buffer bit 31 to the carry.
  - Code 16 shifts right, moves accumulator bit 0 to the carry and fills with buffer bit 31 when `sign_ext` is 1, or with zero when it is 0.
  - Code 17 rotates left through the carry.
  - Code 18 rotates right through the carry.
- R8: Code 19 shifts the accumulator right by `shift_amt`. An amount above 16 acts as 16. The fill is sign bits when `sign_ext` is 1 and zeros when it is 0. Carry and buffer are unchanged.
- R9: Code 20 copies the accumulator into the buffer only when the accumulator is greater than the buffer as a signed value. Code 21 copies it only when the accumulator is less. The accumulator is unchanged either way.
- R10: Code 22 swaps accumulator and buffer in one cycle. Code 25 copies the accumulator into the buffer.
- R11: Code 23 replaces the accumulator with its magnitude and clears the carry. Code 24 replaces it with its two's complement and leaves the carry unchanged. For 0x80000000, both operations return 0x80000000.
- R12: Code 26 loads the zero-extended operand into the accumulator. Code 27 loads the operand into accumulator bits 31:16 and keeps bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe: apply `op_code` this cycle |
| op_code | input | 5 | Operation select (codes in R1–R12) |
| operand | input | 16 | Data operand for logic and load operations |
| shift_amt | input | 5 | Barrel shift amount, capped at 16 |
| sign_ext | input | 1 | 1: right shifts fill with the sign bit; 0: they fill with zero |
| acc_q | output | 32 | Accumulator |
| accb_q | output | 32 | Buffer (second accumulator) |
| carry_q | output | 1 | Carry flag |

## Verification
All three state registers are ports, so a wrong internal value is visible at the outputs on the very next clock edge. Nothing internal is hidden and nothing is delayed. The risk is an error that stays quiet until a later operation uses the corrupted register. Examples are a stale carry consumed by a later add-with-carry or rotate, or a wrong buffer value exposed only by a later compare or 64-bit shift. For that reason the stimulus runs as one continuous chain in which each result feeds the next step. An error in any register then turns into an output mismatch within one or two operations.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    // Operation codes seen at the op_code port
    typedef enum logic [4:0] {
        OP_NOP    = 5'd0,
        OP_ADDBC  = 5'd1,
        OP_SUBBB  = 5'd2,
        OP_ADDB   = 5'd3,
        OP_SUBB   = 5'd4,
        OP_ANDD   = 5'd5,
        OP_ORD    = 5'd6,
        OP_XORD   = 5'd7,
        OP_ANDB   = 5'd8,
        OP_ORB    = 5'd9,
        OP_XORB   = 5'd10,
        OP_SHL1   = 5'd11,
        OP_SHR1   = 5'd12,
        OP_ROL1   = 5'd13,
        OP_ROR1   = 5'd14,
        OP_SHL64  = 5'd15,
        OP_SHR64  = 5'd16,
        OP_ROL64  = 5'd17,
        OP_ROR64  = 5'd18,
        OP_BSR    = 5'd19,
        OP_KEEPGT = 5'd20,
        OP_KEEPLT = 5'd21,
        OP_XCHG   = 5'd22,
        OP_ABS    = 5'd23,
        OP_NEG    = 5'd24,
        OP_SAVEB  = 5'd25,
        OP_LDLO   = 5'd26,
        OP_LDHI   = 5'd27
    } dacc_op_e;

    // Shifter modes
    typedef enum logic [3:0] {
        SH_NONE,
        SH_L1,
        SH_R1,
        SH_RL1,
        SH_RR1,
        SH_L64,
        SH_R64,
        SH_RL64,
        SH_RR64,
        SH_BAR
    } dacc_shmode_e;

    // Adder-operand selection
    typedef enum logic [1:0] {
        AS_ADD,
        AS_ADDC,
        AS_SUB,
        AS_SUBC
    } dacc_asmode_e;

    // Reserved codes start here
    localparam logic [4:0] OP_FIRST_RSVD = 5'd28;

endpackage

// File: rtl/dacc_addsub.sv
module dacc_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0]           a,
    input  logic [W-1:0]           b,
    input  logic                   cin,
    input  dacc_pkg::dacc_asmode_e mode,
    output logic [W-1:0]           sum,
    output logic                   cout
);
    import dacc_pkg::*;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   total;

    always_comb begin
        unique case (mode)
            AS_ADD:  begin b_eff = b;  c_eff = 1'b0; end
            AS_ADDC: begin b_eff = b;  c_eff = cin;  end
            AS_SUB:  begin b_eff = ~b; c_eff = 1'b1; end
            AS_SUBC: begin b_eff = ~b; c_eff = cin;  end
            default: begin b_eff = b;  c_eff = 1'b0; end
        endcase
        total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum   = total[W-1:0];
        cout  = total[W];
    end

endmodule

// File: rtl/dacc_cmp.sv
module dacc_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_gt_b,
    output logic         a_lt_b,
    output logic [W-1:0] a_neg,
    output logic [W-1:0] a_abs
);

    always_comb begin
        a_gt_b = $signed(a) > $signed(b);
        a_lt_b = $signed(a) < $signed(b);
        a_neg  = (~a) + {{(W-1){1'b0}}, 1'b1};
        a_abs  = a[W-1] ? a_neg : a;
    end

endmodule

// File: rtl/dacc_shift.sv
module dacc_shift #(
    parameter int W         = 32,
    parameter int SHAMT_W   = 5,
    parameter int MAX_SHIFT = 16
) (
    input  logic [W-1:0]           acc,
    input  logic [W-1:0]           accb,
    input  logic                   cin,
    input  logic                   sign_ext,
    input  logic [SHAMT_W-1:0]     amt,
    input  dacc_pkg::dacc_shmode_e mode,
    output logic [W-1:0]           acc_n,
    output logic [W-1:0]           accb_n,
    output logic                   cout
);
    import dacc_pkg::*;

    localparam logic [SHAMT_W-1:0] AMT_CAP = SHAMT_W'(MAX_SHIFT);

    logic [SHAMT_W-1:0] eff_amt;
    logic               bar_fill;
    logic [W-1:0]       stage [0:SHAMT_W];

    assign eff_amt  = (amt > AMT_CAP) ? AMT_CAP : amt;
    assign bar_fill = sign_ext & acc[W-1];
    assign stage[0] = acc;

    // Log-depth right shifter: stage k moves by 2**k
    for (genvar k = 0; k < SHAMT_W; k++) begin : g_bar
        localparam int STEP = 2 ** k;
        assign stage[k+1] = eff_amt[k] ? {{STEP{bar_fill}}, stage[k][W-1:STEP]}
                                       : stage[k];
    end

    always_comb begin
        acc_n  = acc;
        accb_n = accb;
        cout   = cin;
        unique case (mode)
            SH_NONE: ;
            SH_L1: begin
                cout  = acc[W-1];
                acc_n = {acc[W-2:0], 1'b0};
            end
            SH_R1: begin
                cout  = acc[0];
                acc_n = {sign_ext & acc[W-1], acc[W-1:1]};
            end
            SH_RL1: begin
                cout  = acc[W-1];
                acc_n = {acc[W-2:0], cin};
            end
            SH_RR1: begin
                cout  = acc[0];
                acc_n = {cin, acc[W-1:1]};
            end
            SH_L64: begin
                cout   = accb[W-1];
                accb_n = {accb[W-2:0], acc[W-1]};
                acc_n  = {acc[W-2:0], 1'b0};
            end
            SH_R64: begin
                cout   = acc[0];
                accb_n = {sign_ext & accb[W-1], accb[W-1:1]};
                acc_n  = {accb[0], acc[W-1:1]};
            end
            SH_RL64: begin
                cout   = accb[W-1];
                accb_n = {accb[W-2:0], acc[W-1]};
                acc_n  = {acc[W-2:0], cin};
            end
            SH_RR64: begin
                cout   = acc[0];
                accb_n = {cin, accb[W-1:1]};
                acc_n  = {accb[0], acc[W-1:1]};
            end
            SH_BAR: begin
                acc_n = stage[SHAMT_W];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dacc_shift_alu.sv
module dacc_shift_alu #(
    parameter int ACC_W     = 32,
    parameter int OPND_W    = ACC_W / 2,
    parameter int SHAMT_W   = 5,
    parameter int MAX_SHIFT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [4:0]         op_code,
    input  logic [OPND_W-1:0]  operand,
    input  logic [SHAMT_W-1:0] shift_amt,
    input  logic               sign_ext,
    output logic [ACC_W-1:0]   acc_q,
    output logic [ACC_W-1:0]   accb_q,
    output logic               carry_q
);
    import dacc_pkg::*;

    localparam int UP_W = ACC_W - OPND_W;

    dacc_op_e     op;
    dacc_shmode_e sh_mode;
    dacc_asmode_e as_mode;

    logic [ACC_W-1:0] opnd_ext;
    logic [ACC_W-1:0] as_sum;
    logic             as_cout;
    logic [ACC_W-1:0] sh_acc, sh_accb;
    logic             sh_cout;
    logic             gt, lt;
    logic [ACC_W-1:0] neg_v, abs_v;

    logic [ACC_W-1:0] acc_d, accb_d;
    logic             carry_d;

    assign op       = dacc_op_e'(op_code);
    assign opnd_ext = {{UP_W{1'b0}}, operand};

    // Operation decode to unit modes
    always_comb begin
        sh_mode = SH_NONE;
        as_mode = AS_ADD;
        unique case (op)
            OP_ADDBC: as_mode = AS_ADDC;
            OP_SUBBB: as_mode = AS_SUBC;
            OP_SUBB:  as_mode = AS_SUB;
            OP_SHL1:  sh_mode = SH_L1;
            OP_SHR1:  sh_mode = SH_R1;
            OP_ROL1:  sh_mode = SH_RL1;
            OP_ROR1:  sh_mode = SH_RR1;
            OP_SHL64: sh_mode = SH_L64;
            OP_SHR64: sh_mode = SH_R64;
            OP_ROL64: sh_mode = SH_RL64;
            OP_ROR64: sh_mode = SH_RR64;
            OP_BSR:   sh_mode = SH_BAR;
            default:  ;
        endcase
    end

    dacc_addsub #(.W(ACC_W)) u_addsub (
        .a    (acc_q),
        .b    (accb_q),
        .cin  (carry_q),
        .mode (as_mode),
        .sum  (as_sum),
        .cout (as_cout)
    );

    dacc_shift #(.W(ACC_W), .SHAMT_W(SHAMT_W), .MAX_SHIFT(MAX_SHIFT)) u_shift (
        .acc      (acc_q),
        .accb     (accb_q),
        .cin      (carry_q),
        .sign_ext (sign_ext),
        .amt      (shift_amt),
        .mode     (sh_mode),
        .acc_n    (sh_acc),
        .accb_n   (sh_accb),
        .cout     (sh_cout)
    );

    dacc_cmp #(.W(ACC_W)) u_cmp (
        .a      (acc_q),
        .b      (accb_q),
        .a_gt_b (gt),
        .a_lt_b (lt),
        .a_neg  (neg_v),
        .a_abs  (abs_v)
    );

    // Next-state selection
    always_comb begin
        acc_d   = acc_q;
        accb_d  = accb_q;
        carry_d = carry_q;
        if (op_valid) begin
            unique case (op)
                OP_ADDBC, OP_SUBBB, OP_ADDB, OP_SUBB: begin
                    acc_d   = as_sum;
                    carry_d = as_cout;
                end
                OP_ANDD:  acc_d = acc_q & opnd_ext;
                OP_ORD:   acc_d = acc_q | opnd_ext;
                OP_XORD:  acc_d = acc_q ^ opnd_ext;
                OP_ANDB:  acc_d = acc_q & accb_q;
                OP_ORB:   acc_d = acc_q | accb_q;
                OP_XORB:  acc_d = acc_q ^ accb_q;
                OP_SHL1, OP_SHR1, OP_ROL1, OP_ROR1,
                OP_SHL64, OP_SHR64, OP_ROL64, OP_ROR64, OP_BSR: begin
                    acc_d   = sh_acc;
                    accb_d  = sh_accb;
                    carry_d = sh_cout;
                end
                OP_KEEPGT: if (gt) accb_d = acc_q;
                OP_KEEPLT: if (lt) accb_d = acc_q;
                OP_XCHG: begin
                    acc_d  = accb_q;
                    accb_d = acc_q;
                end
                OP_ABS: begin
                    acc_d   = abs_v;
                    carry_d = 1'b0;
                end
                OP_NEG:   acc_d  = neg_v;
                OP_SAVEB: accb_d = acc_q;
                OP_LDLO:  acc_d  = opnd_ext;
                OP_LDHI:  acc_d  = {operand, acc_q[OPND_W-1:0]};
                default:  ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            accb_q  <= '0;
            carry_q <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            accb_q  <= accb_d;
            carry_q <= carry_d;
        end
    end

endmodule

// File: rtl/dacc_shift_alu_chk.sv
module dacc_shift_alu_chk #(
    parameter int ACC_W   = 32,
    parameter int OPND_W  = ACC_W / 2,
    parameter int SHAMT_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic [4:0]         op_code,
    input logic [OPND_W-1:0]  operand,
    input logic [SHAMT_W-1:0] shift_amt,
    input logic               sign_ext,
    input logic [ACC_W-1:0]   acc_q,
    input logic [ACC_W-1:0]   accb_q,
    input logic               carry_q
);
    localparam logic [ACC_W-1:0] MOST_NEG = {1'b1, {(ACC_W-1){1'b0}}};

    logic unused_ok;
    assign unused_ok = ^{operand, shift_amt, sign_ext};

    assert_idle_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code >= 5'd28) |=>
            ($stable(acc_q) && $stable(accb_q) && $stable(carry_q)));

    assert_and_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd5) |=>
            (acc_q[ACC_W-1:OPND_W] == '0 && $stable(accb_q)));

    assert_rol64_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd17) |=>
            (carry_q == $past(accb_q[ACC_W-1]) && acc_q[0] == $past(carry_q)));

    assert_barrel_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd19) |=> ($stable(carry_q) && $stable(accb_q)));

    assert_keepgt_grow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd20) |=>
            ($signed(accb_q) >= $signed($past(accb_q)) && $stable(acc_q)));

    assert_xchg_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd22) |=>
            (acc_q == $past(accb_q) && accb_q == $past(acc_q)));

    assert_abs_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd23) |=>
            (!carry_q && (!acc_q[ACC_W-1] || acc_q == MOST_NEG)));

endmodule

bind dacc_shift_alu dacc_shift_alu_chk #(
    .ACC_W   (ACC_W),
    .OPND_W  (OPND_W),
    .SHAMT_W (SHAMT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .operand   (operand),
    .shift_amt (shift_amt),
    .sign_ext  (sign_ext),
    .acc_q     (acc_q),
    .accb_q    (accb_q),
    .carry_q   (carry_q)
);

// File: tb/dacc_shift_alu_tb_top.sv
`timescale 1ns/1ps
module dacc_shift_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [15:0] operand = '0;
    logic [4:0]  shift_amt = '0;
    logic        sign_ext = 1'b0;
    logic [31:0] acc_q, accb_q;
    logic        carry_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dacc_shift_alu dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .operand   (operand),
        .shift_amt (shift_amt),
        .sign_ext  (sign_ext),
        .acc_q     (acc_q),
        .accb_q    (accb_q),
        .carry_q   (carry_q)
    );

    // Vector: op(5) operand(16) amt(5) sx(1) valid(1) acc(32) accb(32) carry(1) req(8)
    localparam int NV = 38;
    localparam logic [100:0] VEC [NV] = '{
        {5'd27, 16'h1234, 5'd0,  1'b0, 1'b1, 32'h12340000, 32'h00000000, 1'b0, 8'd12}, // R12
        {5'd6,  16'h5678, 5'd0,  1'b0, 1'b1, 32'h12345678, 32'h00000000, 1'b0, 8'd4},  // R4
        {5'd25, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h12345678, 32'h12345678, 1'b0, 8'd10}, // R10
        {5'd26, 16'h0001, 5'd0,  1'b0, 1'b1, 32'h00000001, 32'h12345678, 1'b0, 8'd12}, // R12
        {5'd3,  16'h0000, 5'd0,  1'b0, 1'b1, 32'h12345679, 32'h12345678, 1'b0, 8'd2},  // R2
        {5'd22, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h12345678, 32'h12345679, 1'b0, 8'd10}, // R10
        {5'd4,  16'h0000, 5'd0,  1'b0, 1'b1, 32'hFFFFFFFF, 32'h12345679, 1'b0, 8'd3},  // R3
        {5'd1,  16'h0000, 5'd0,  1'b0, 1'b1, 32'h12345678, 32'h12345679, 1'b1, 8'd2},  // R2
        {5'd2,  16'h0000, 5'd0,  1'b0, 1'b1, 32'hFFFFFFFF, 32'h12345679, 1'b0, 8'd3},  // R3
        {5'd2,  16'h0000, 5'd0,  1'b0, 1'b1, 32'hEDCBA985, 32'h12345679, 1'b1, 8'd3},  // R3
        {5'd23, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h1234567B, 32'h12345679, 1'b0, 8'd11}, // R11
        {5'd24, 16'h0000, 5'd0,  1'b0, 1'b1, 32'hEDCBA985, 32'h12345679, 1'b0, 8'd11}, // R11
        {5'd21, 16'h0000, 5'd0,  1'b0, 1'b1, 32'hEDCBA985, 32'hEDCBA985, 1'b0, 8'd9},  // R9
        {5'd20, 16'h0000, 5'd0,  1'b0, 1'b1, 32'hEDCBA985, 32'hEDCBA985, 1'b0, 8'd9},  // R9
        {5'd26, 16'h8001, 5'd0,  1'b0, 1'b1, 32'h00008001, 32'hEDCBA985, 1'b0, 8'd12}, // R12
        {5'd20, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h00008001, 32'h00008001, 1'b0, 8'd9},  // R9
        {5'd15, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h00010002, 32'h00010002, 1'b0, 8'd7},  // R7
        {5'd27, 16'h8000, 5'd0,  1'b0, 1'b1, 32'h80000002, 32'h00010002, 1'b0, 8'd12}, // R12
        {5'd17, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h00000004, 32'h00020005, 1'b0, 8'd7},  // R7
        {5'd18, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h80000002, 32'h00010002, 1'b0, 8'd7},  // R7
        {5'd12, 16'h0000, 5'd0,  1'b1, 1'b1, 32'hC0000001, 32'h00010002, 1'b0, 8'd6},  // R6
        {5'd12, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h60000000, 32'h00010002, 1'b1, 8'd6},  // R6
        {5'd13, 16'h0000, 5'd0,  1'b0, 1'b1, 32'hC0000001, 32'h00010002, 1'b0, 8'd6},  // R6
        {5'd14, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h60000000, 32'h00010002, 1'b1, 8'd6},  // R6
        {5'd11, 16'h0000, 5'd0,  1'b0, 1'b1, 32'hC0000000, 32'h00010002, 1'b0, 8'd6},  // R6
        {5'd19, 16'h0000, 5'd4,  1'b1, 1'b1, 32'hFC000000, 32'h00010002, 1'b0, 8'd8},  // R8
        {5'd19, 16'h0000, 5'd31, 1'b0, 1'b1, 32'h0000FC00, 32'h00010002, 1'b0, 8'd8},  // R8 cap
        {5'd27, 16'hFFFF, 5'd0,  1'b0, 1'b1, 32'hFFFFFC00, 32'h00010002, 1'b0, 8'd12}, // R12
        {5'd5,  16'h0F0F, 5'd0,  1'b0, 1'b1, 32'h00000C00, 32'h00010002, 1'b0, 8'd4},  // R4
        {5'd10, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h00010C02, 32'h00010002, 1'b0, 8'd5},  // R5
        {5'd9,  16'h0000, 5'd0,  1'b0, 1'b1, 32'h00010C02, 32'h00010002, 1'b0, 8'd5},  // R5
        {5'd8,  16'h0000, 5'd0,  1'b0, 1'b1, 32'h00010002, 32'h00010002, 1'b0, 8'd5},  // R5
        {5'd7,  16'hFFFF, 5'd0,  1'b0, 1'b1, 32'h0001FFFD, 32'h00010002, 1'b0, 8'd4},  // R4
        {5'd16, 16'h0000, 5'd0,  1'b1, 1'b1, 32'h0000FFFE, 32'h00008001, 1'b1, 8'd7},  // R7
        {5'd19, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h0000FFFE, 32'h00008001, 1'b1, 8'd8},  // R8
        {5'd31, 16'hFFFF, 5'd0,  1'b0, 1'b1, 32'h0000FFFE, 32'h00008001, 1'b1, 8'd1},  // R1
        {5'd3,  16'h0000, 5'd0,  1'b0, 1'b0, 32'h0000FFFE, 32'h00008001, 1'b1, 8'd1},  // R1
        {5'd28, 16'h0000, 5'd0,  1'b0, 1'b1, 32'h0000FFFE, 32'h00008001, 1'b1, 8'd1}   // R1
    };

    task automatic compare(input int rq, input logic [31:0] ea,
                           input logic [31:0] eb, input logic ec);
        n_checks++;
        if (acc_q !== ea || accb_q !== eb || carry_q !== ec) begin
            n_fail++;
            $display("FAIL R%0d: acc=%h accb=%h c=%b expected acc=%h accb=%h c=%b",
                     rq, acc_q, accb_q, carry_q, ea, eb, ec);
        end
    endtask

    task automatic step(input logic [4:0] op, input logic [15:0] opnd,
                        input logic [4:0] amt, input logic sx, input logic vld,
                        input logic [31:0] ea, input logic [31:0] eb,
                        input logic ec, input int rq);
        op_code   = op;
        operand   = opnd;
        shift_amt = amt;
        sign_ext  = sx;
        op_valid  = vld;
        @(negedge clk);
        op_valid  = 1'b0;
        compare(rq, ea, eb, ec);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: acc=%h expected run to finish", acc_q);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        compare(1, 32'h0, 32'h0, 1'b0); // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][100:96], VEC[i][95:80], VEC[i][79:75], VEC[i][74], VEC[i][73],
                 VEC[i][72:41], VEC[i][40:9], VEC[i][8], int'(VEC[i][7:0]));
        end

        // R1: reset mid-run clears all state
        rst_n = 1'b0;
        @(negedge clk);
        compare(1, 32'h0, 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Most-negative value and carry-in corner cases
        step(5'd26, 16'h0001, 5'd0, 1'b0, 1'b1, 32'h00000001, 32'h0, 1'b0, 12); // R12
        step(5'd14, 16'h0000, 5'd0, 1'b0, 1'b1, 32'h00000000, 32'h0, 1'b1, 6);  // R6
        step(5'd27, 16'h8000, 5'd0, 1'b0, 1'b1, 32'h80000000, 32'h0, 1'b1, 12); // R12
        step(5'd24, 16'h0000, 5'd0, 1'b0, 1'b1, 32'h80000000, 32'h0, 1'b1, 11); // R11 neg min, carry kept
        step(5'd23, 16'h0000, 5'd0, 1'b0, 1'b1, 32'h80000000, 32'h0, 1'b0, 11); // R11 abs min
        step(5'd25, 16'h0000, 5'd0, 1'b0, 1'b1, 32'h80000000, 32'h80000000, 1'b0, 10); // R10
        step(5'd1,  16'h0000, 5'd0, 1'b0, 1'b1, 32'h00000000, 32'h80000000, 1'b1, 2);  // R2 carry-out
        step(5'd1,  16'h0000, 5'd0, 1'b0, 1'b1, 32'h80000001, 32'h80000000, 1'b0, 2);  // R2 carry-in

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule